// File: doc/BRIEF.md
# Set-clear interrupt mask controller

This block gathers five single-cycle event pulses into sticky status flags and drives one level-sensitive interrupt line whenever a flagged event is also enabled in a mask. Software never writes the mask as a whole word. It sets mask bits by writing ones to an enable offset and drops them by writing ones to a disable offset. This lets independent agents change their own bits without a read-modify-write race. Status flags are dropped only through a separate write-one-to-clear command offset.

A simple strobe interface carries register accesses. A write takes one cycle with `wr_en`, `addr` and `wdata`. A read presents `rd_en` and `addr`, and `rdata` holds the selected word from the next cycle until the next read. A read-only word also reports four externally supplied invalid-entry flags.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After reset the status flags, the mask, `irq` and `rdata` are all zero.
- R2: A pulse on event input bit i sets status bit i (0 update-acknowledge, 1 alarm, 2 second, 3 time, 4 calendar), and the bit stays set until cleared.
- R3: A read at offset 0x18 returns the status flags in bits 4:0, with all upper bits zero.
- R4: Writing offset 0x1C clears each status bit whose `wdata` bit is one, and leaves bits written zero unchanged.
- R5: When an event pulse and a clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Writing offset 0x20 sets each mask bit whose `wdata` bit is one, and leaves the other mask bits unchanged.
- R7: Writing offset 0x24 clears each mask bit whose `wdata` bit is one, and leaves the other mask bits unchanged.
- R8: A read at offset 0x28 returns the mask in bits 4:0. Writes to 0x28 or 0x18 change neither the mask nor the status.
- R9: `irq` is a registered level. It is high in the cycle after status AND mask is nonzero, and it falls the cycle after the last enabled flag is cleared or masked.
- R10: A read at offset 0x2C returns the invalid-entry flags in bits 3:0: time (bit 0), calendar (bit 1), time alarm (bit 2) and calendar alarm (bit 3).
- R11: `rdata` changes only on the clock edge that samples `rd_en`. A read at an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 5 | Event pulses, one per status bit |
| inval_i | input | 4 | Invalid-entry flags shown at 0x2C |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the in-line properties check the following:
- an event sets its flag;
- a clear without a colliding event drops its flag;
- enable and disable writes move only the addressed mask bits;
- both registers hold when nothing touches them;
- `irq` is never high unless an enabled flag was set one cycle earlier.

Only the directed scenarios can show the rest. These are the offset decoding, the word layout seen on reads, the exact cycle in which `irq` falls after a clear or a disable, the event-over-clear collision, and the fact that writes to read-only offsets are ignored.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int EVT_W  = 5;
  localparam int INV_W  = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [7:0] OFF_STATUS  = 8'h18;
  localparam logic [7:0] OFF_CLEAR   = 8'h1C;
  localparam logic [7:0] OFF_ENABLE  = 8'h20;
  localparam logic [7:0] OFF_DISABLE = 8'h24;
  localparam logic [7:0] OFF_MASK    = 8'h28;
  localparam logic [7:0] OFF_INVALID = 8'h2C;
endpackage

// File: rtl/irqm_regif.sv
module irqm_regif
  import irqm_pkg::*;
#(
  parameter int EW = EVT_W,
  parameter int IW = INV_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [EW-1:0] status,
  input  logic [EW-1:0] mask,
  input  logic [IW-1:0] inval,
  output logic [EW-1:0] stat_clr,
  output logic [EW-1:0] mask_set,
  output logic [EW-1:0] mask_clr,
  output logic [DW-1:0] rdata
);
  localparam int PAD_E = DW - EW;
  localparam int PAD_I = DW - IW;

  logic          hit_clr, hit_en, hit_dis;
  logic [DW-1:0] rd_mux;

  assign hit_clr = wr_en && (addr == AW'(OFF_CLEAR));
  assign hit_en  = wr_en && (addr == AW'(OFF_ENABLE));
  assign hit_dis = wr_en && (addr == AW'(OFF_DISABLE));

  assign stat_clr = hit_clr ? wdata[EW-1:0] : '0;
  assign mask_set = hit_en  ? wdata[EW-1:0] : '0;
  assign mask_clr = hit_dis ? wdata[EW-1:0] : '0;

  generate
    if (DW > EW) begin : g_unused
      logic unused_hi;
      assign unused_hi = ^wdata[DW-1:EW];
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (addr == AW'(OFF_STATUS))       rd_mux = {{PAD_E{1'b0}}, status};
    else if (addr == AW'(OFF_MASK))    rd_mux = {{PAD_E{1'b0}}, mask};
    else if (addr == AW'(OFF_INVALID)) rd_mux = {{PAD_I{1'b0}}, inval};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/irqm_status.sv
module irqm_status #(
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] evt,
  input  logic [EW-1:0] clr,
  output logic [EW-1:0] status
);
  logic [EW-1:0] status_nxt;

  generate
    for (genvar i = 0; i < EW; i++) begin : g_bit
      always_comb status_nxt[i] = evt[i] | (status[i] & ~clr[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_nxt;
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt)));
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~evt) != '0) |=> ((status & $past(clr & ~evt)) == '0));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0 && clr == '0) |=> $stable(status));
endmodule

// File: rtl/irqm_mask.sv
module irqm_mask #(
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] set,
  input  logic [EW-1:0] clr,
  output logic [EW-1:0] mask
);
  logic [EW-1:0] mask_nxt;
  logic          mask_we;

  assign mask_we = (set != '0) || (clr != '0);

  always_comb mask_nxt = (mask & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= mask_nxt;
  end

  a_r6_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((mask & $past(set)) == $past(set)));
  a_r7_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~set) != '0) |=> ((mask & $past(clr & ~set)) == '0));
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set == '0 && clr == '0) |=> $stable(mask));
endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl
  import irqm_pkg::*;
#(
  parameter int EW = EVT_W,
  parameter int IW = INV_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] evt_i,
  input  logic [IW-1:0] inval_i,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  logic [EW-1:0] status, mask, stat_clr, mask_set, mask_clr;
  logic          irq_nxt;

  irqm_regif #(.EW(EW), .IW(IW), .AW(AW), .DW(DW)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .status(status), .mask(mask), .inval(inval_i),
    .stat_clr(stat_clr), .mask_set(mask_set), .mask_clr(mask_clr),
    .rdata(rdata)
  );

  irqm_status #(.EW(EW)) u_status (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .clr(stat_clr), .status(status)
  );

  irqm_mask #(.EW(EW)) u_mask (
    .clk(clk), .rst_n(rst_n), .set(mask_set), .clr(mask_clr), .mask(mask)
  );

  always_comb irq_nxt = |(status & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_nxt;
  end

  a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((status & mask) != '0));
endmodule

// File: tb/irq_setclr_ctrl_bench.sv
module irq_setclr_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  evt_i = '0;
  logic [3:0]  inval_i = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  irq_setclr_ctrl u_irq_setclr_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .inval_i(inval_i),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(logic [4:0] v);
    @(negedge clk); evt_i = v;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rdata", rdata, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(8'h18, d); chk("R1 status", d, 0);
    rd(8'h28, d); chk("R1 mask", d, 0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse(5'b00010); rd(8'h18, d); chk("R2 alarm bit1", d, 32'h02);
    pulse(5'b00100); rd(8'h18, d); chk("R2 second bit2", d, 32'h06);
    pulse(5'b11001); rd(8'h18, d); chk("R3 status word", d, 32'h1F);
    chk("R9 masked off", {31'b0, irq}, 0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(8'h1C, 32'h05); rd(8'h18, d); chk("R4 clear ones", d, 32'h1A);
    wr(8'h1C, 32'h00); rd(8'h18, d); chk("R4 zeros no effect", d, 32'h1A);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'h20, 32'h03); rd(8'h28, d); chk("R6 enable", d, 32'h03);
    wr(8'h20, 32'h00); rd(8'h28, d); chk("R6 zeros no effect", d, 32'h03);
    wr(8'h24, 32'h01); rd(8'h28, d); chk("R7 disable", d, 32'h02);
    wr(8'h24, 32'h00); rd(8'h28, d); chk("R7 zeros no effect", d, 32'h02);
  endtask

  task automatic t_irq();
    chk("R9 irq on", {31'b0, irq}, 1);
    wr(8'h24, 32'h02);
    chk("R9 still high one cycle", {31'b0, irq}, 1);
    @(negedge clk); chk("R9 falls after mask", {31'b0, irq}, 0);
    wr(8'h20, 32'h02);
    chk("R9 registered rise", {31'b0, irq}, 0);
    @(negedge clk); chk("R9 rises", {31'b0, irq}, 1);
    wr(8'h1C, 32'h02);
    chk("R9 still high after clear", {31'b0, irq}, 1);
    @(negedge clk); chk("R9 falls after clear", {31'b0, irq}, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(5'b00001); rd(8'h18, d); chk("R2 update-ack bit0", d, 32'h19);
    @(negedge clk); evt_i = 5'b00001; wr_en = 1'b1; addr = 8'h1C; wdata = 32'h11;
    @(negedge clk); evt_i = '0; wr_en = 1'b0; wdata = '0;
    rd(8'h18, d); chk("R5 event wins", d, 32'h09);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    wr(8'h28, 32'h1F); rd(8'h28, d); chk("R8 mask write ignored", d, 32'h02);
    wr(8'h18, 32'h00); rd(8'h18, d); chk("R8 status write ignored", d, 32'h09);
  endtask

  task automatic t_read();
    logic [31:0] d;
    inval_i = 4'b1010;
    rd(8'h2C, d); chk("R10 invalid flags", d, 32'h0A);
    @(negedge clk); rd_en = 1'b1; addr = 8'h30;
    #1 chk("R11 no change before edge", rdata, 32'h0A);
    @(negedge clk); rd_en = 1'b0;
    chk("R11 unmapped zero", rdata, 0);
    addr = 8'h18;
    @(negedge clk); chk("R11 held without rd_en", rdata, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_events();
    t_clear();
    t_mask();
    t_irq();
    t_collide();
    t_readonly();
    t_read();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule